// File: doc/BRIEF.md
# External Memory Byte-Lane Strobe Controller

This block turns single internal memory requests into the control and data signals of an external static memory bus with one chip select. A request carries a byte address, a read or write flag, a size (byte or halfword) and write data. The block runs the bus cycle and then returns read data with a one-cycle done pulse. Two configuration inputs describe the device attached to the chip select. The first gives the bus width, 8 or 16 bits. The second applies only to a 16-bit bus and picks the write scheme: one write strobe per byte lane, or byte-enable lines with a single write strobe.

Three output pins are shared and change meaning with the configuration. On a 16-bit bus with per-lane write strobes, a pair of 8-bit devices sits side by side. The lower write pin strobes the low lane, the upper write pin strobes the high lane, and the address-bit-0 pin is unused. On a 16-bit bus with byte enables, a single 16-bit device reads the address-bit-0 pin as its low-byte enable and the upper write pin as its high-byte enable. On an 8-bit bus the address-bit-0 pin carries the byte address, and a halfword request becomes two byte cycles.

Every access keeps the chip select low for a strobe cycle followed by an end cycle. The read and write strobes are low only in the strobe cycle, so they rise one cycle before the chip select is released. Requests are taken only while the bus is idle.

Top module: `xmem_lane_ctrl`

## Requirements
- R1: After reset and whenever no access is running, bus_cs_n, bus_rd_n, bus_wr_lo_n, bus_wr_hi_n and bus_a0_lb_n are all 1, bus_dq_oe and rsp_done are 0, and bus_addr and rsp_rdata are 0 after reset.
- R2: A request with req_valid=1 sampled while idle starts an access on the next cycle. bus_cs_n is 0 for a strobe cycle and then an end cycle. The read or write strobe is low only in the strobe cycle. rsp_done is 1 in the final end cycle, and bus_cs_n returns to 1 on the cycle after it.
- R3: With cfg_wide=1 and cfg_bsel=0 (per-lane write strobes), a write pulls bus_wr_lo_n low for the low lane and bus_wr_hi_n low for the high lane, and bus_a0_lb_n stays 1 throughout.
- R4: With cfg_wide=1 and cfg_bsel=0, a read of either size pulls only bus_rd_n low, and both write pins stay 1.
- R5: With cfg_wide=1 and cfg_bsel=1 (byte enables), bus_a0_lb_n is the active-low low-lane enable and bus_wr_hi_n is the active-low high-lane enable. Both are held through the whole access. bus_wr_lo_n is the only write strobe, and bus_rd_n is the output-enable strobe.
- R6: A byte access selects the low lane (bits 7:0) when req_addr[0]=0 and the high lane (bits 15:8) when req_addr[0]=1. A halfword access selects both lanes and ignores req_addr[0].
- R7: During an access, bus_addr equals req_addr[ADDR_W-1:1] of the accepted request. On a 16-bit bus its lowest bit is the memory's word address bit 0.
- R8: With cfg_wide=0, bus_a0_lb_n carries the byte address bit 0, writes strobe only bus_wr_lo_n, bus_wr_hi_n stays 1, and a byte access is one strobe and end cycle pair.
- R9: With cfg_wide=0, a halfword access runs two back-to-back byte cycles with bus_cs_n held low for four cycles. The first cycle has bus_a0_lb_n=0 and carries bits 7:0. The second has bus_a0_lb_n=1 and carries bits 15:8. rsp_done is raised only at the end of the second cycle.
- R10: bus_dq_oe is 1 through a write access and 0 otherwise. A byte write, or one byte cycle of a split halfword, drives that byte on both lanes. A 16-bit halfword write drives req_wdata. A byte read returns the byte in rsp_rdata[7:0] with zeros above. A halfword read returns the high lane in bits 15:8.
- R11: While an access is running, req_valid and the request fields are ignored; the running access and bus_addr do not change, and no new access starts when it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_half | input | 1 | 1 for halfword, 0 for byte |
| req_wdata | input | DATA_W | Write data; a byte uses bits 7:0 |
| cfg_wide | input | 1 | Chip select bus width: 1 = 16-bit, 0 = 8-bit |
| cfg_bsel | input | 1 | 16-bit write scheme: 1 = byte enables, 0 = per-lane write strobes |
| rsp_rdata | output | DATA_W | Read data, valid while rsp_done is 1 |
| rsp_done | output | 1 | One-cycle completion pulse |
| bus_addr | output | ADDR_W-1 | External address bits above bit 0 |
| bus_dq_o | output | DATA_W | Data driven to the bus |
| bus_dq_oe | output | 1 | Data bus drive enable (tri-state control) |
| bus_dq_i | input | DATA_W | Data read from the bus |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read / output enable, active low |
| bus_wr_lo_n | output | 1 | Low-lane write strobe or single write enable, active low |
| bus_wr_hi_n | output | 1 | High-lane write strobe or high-byte enable, active low |
| bus_a0_lb_n | output | 1 | Address bit 0 or low-byte enable (active low) |

## Verification
The bench goes after how the three shared pins change meaning. A swapped lane decode would strobe the wrong write pin. A per-lane write design that forgot to park the address-bit-0 pin would leave it toggling. A byte-enable design that dropped its enables in the end cycle would leave the enable pins high there. The 8-bit halfword is driven at an odd address: a design that honoured the address bit would start at the high byte, and a design that raised done after the first byte cycle would report half of the data. A request held during an access checks that the latched address does not move and that no second access follows.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_STB  = 2'd1,
      ST_END  = 2'd2
   } acc_state_e;

   // latched request and configuration of the running access
   typedef struct packed {
      logic wr;
      logic half;
      logic wide;
      logic bsel;
      logic a0;
   } acc_req_s;
endpackage

// File: rtl/xmem_ctl_fsm.sv
module xmem_ctl_fsm
   import xmem_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_half,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              cfg_wide,
   input  logic              cfg_bsel,
   output acc_state_e        st,
   output logic              beat,
   output acc_req_s          cur,
   output logic [ADDR_W-2:0] addr_hi,
   output logic [DATA_W-1:0] wdata,
   output logic              done
);
   logic split;

   // a halfword on a narrow bus needs two byte cycles
   assign split = !cur.wide && cur.half;
   assign done  = (st == ST_END) && !(split && !beat);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         beat    <= 1'b0;
         cur     <= '0;
         addr_hi <= '0;
         wdata   <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  st      <= ST_STB;
                  beat    <= 1'b0;
                  cur     <= '{wr: req_write, half: req_half, wide: cfg_wide,
                               bsel: cfg_bsel, a0: req_addr[0]};
                  addr_hi <= req_addr[ADDR_W-1:1];
                  wdata   <= req_wdata;
               end
            end
            ST_STB: st <= ST_END;
            ST_END: begin
               if (split && !beat) begin
                  beat <= 1'b1;
                  st   <= ST_STB;
               end else begin
                  st <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xmem_pin_dec.sv
module xmem_pin_dec
   import xmem_pkg::*;
(
   input  acc_state_e st,
   input  acc_req_s   cur,
   input  logic       beat,
   output logic       cs_n,
   output logic       rd_n,
   output logic       wr_lo_n,
   output logic       wr_hi_n,
   output logic       a0_lb_n,
   output logic       dq_oe
);
   logic       active;
   logic       stb;
   logic [1:0] lane_sel;
   logic       byte_a0;

   assign active   = (st != ST_IDLE);
   assign stb      = (st == ST_STB);
   assign lane_sel = {cur.half | cur.a0, cur.half | !cur.a0};
   assign byte_a0  = cur.half ? beat : cur.a0;

   assign cs_n  = !active;
   assign rd_n  = !(stb && !cur.wr);
   assign dq_oe = active && cur.wr;

   always_comb begin
      if (!cur.wide) begin
         // narrow bus: pin carries the byte address, one write strobe
         a0_lb_n = active ? byte_a0 : 1'b1;
         wr_lo_n = !(stb && cur.wr);
         wr_hi_n = 1'b1;
      end else if (!cur.bsel) begin
         // per-lane write strobes, address pin parked
         a0_lb_n = 1'b1;
         wr_lo_n = !(stb && cur.wr && lane_sel[0]);
         wr_hi_n = !(stb && cur.wr && lane_sel[1]);
      end else begin
         // byte enables held for the whole access, single write strobe
         a0_lb_n = !(active && lane_sel[0]);
         wr_hi_n = !(active && lane_sel[1]);
         wr_lo_n = !(stb && cur.wr);
      end
   end
endmodule

// File: rtl/xmem_lane_data.sv
module xmem_lane_data #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic              wide,
   input  logic              half,
   input  logic              a0,
   input  logic              beat,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] dq_i,
   output logic [DATA_W-1:0] dq_o,
   output logic [DATA_W-1:0] rdata
);
   localparam int LANES = DATA_W / 8;

   logic [DATA_W-1:0] rd_nxt;
   logic [7:0]        beat_byte;

   assign beat_byte = (half && beat) ? wdata[15:8] : wdata[7:0];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] w_b;
      logic [7:0] r_b;

      assign w_b = (wide && half) ? wdata[8*l +: 8] : beat_byte;
      assign dq_o[8*l +: 8]   = w_b;
      assign rd_nxt[8*l +: 8] = r_b;

      if (l == 0) begin : g_lo
         always_comb begin
            if (wide)
               r_b = (half || !a0) ? dq_i[7:0] : dq_i[15:8];
            else
               r_b = (half && beat) ? rdata[7:0] : dq_i[7:0];
         end
      end else begin : g_hi
         always_comb begin
            if (wide)
               r_b = half ? dq_i[8*l +: 8] : 8'h00;
            else
               r_b = (half && beat) ? dq_i[7:0] : 8'h00;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '0;
      else if (cap_en)
         rdata <= rd_nxt;
   end
endmodule

// File: rtl/xmem_lane_ctrl.sv
module xmem_lane_ctrl
   import xmem_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_half,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              cfg_wide,
   input  logic              cfg_bsel,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done,
   output logic [ADDR_W-2:0] bus_addr,
   output logic [DATA_W-1:0] bus_dq_o,
   output logic              bus_dq_oe,
   input  logic [DATA_W-1:0] bus_dq_i,
   output logic              bus_cs_n,
   output logic              bus_rd_n,
   output logic              bus_wr_lo_n,
   output logic              bus_wr_hi_n,
   output logic              bus_a0_lb_n
);
   if (DATA_W != 16) begin : g_bad_dw
      $error("xmem_lane_ctrl: DATA_W must be 16");
   end
   if (ADDR_W < 2) begin : g_bad_aw
      $error("xmem_lane_ctrl: ADDR_W must be at least 2");
   end

   acc_state_e        st;
   acc_req_s          cur;
   logic              beat;
   logic [DATA_W-1:0] wdata;

   xmem_ctl_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_write (req_write),
      .req_half  (req_half),
      .req_wdata (req_wdata),
      .cfg_wide  (cfg_wide),
      .cfg_bsel  (cfg_bsel),
      .st        (st),
      .beat      (beat),
      .cur       (cur),
      .addr_hi   (bus_addr),
      .wdata     (wdata),
      .done      (rsp_done)
   );

   xmem_pin_dec u_pins (
      .st      (st),
      .cur     (cur),
      .beat    (beat),
      .cs_n    (bus_cs_n),
      .rd_n    (bus_rd_n),
      .wr_lo_n (bus_wr_lo_n),
      .wr_hi_n (bus_wr_hi_n),
      .a0_lb_n (bus_a0_lb_n),
      .dq_oe   (bus_dq_oe)
   );

   xmem_lane_data #(.DATA_W(DATA_W)) u_data (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en ((st == ST_STB) && !cur.wr),
      .wide   (cur.wide),
      .half   (cur.half),
      .a0     (cur.a0),
      .beat   (beat),
      .wdata  (wdata),
      .dq_i   (bus_dq_i),
      .dq_o   (bus_dq_o),
      .rdata  (rsp_rdata)
   );
endmodule

// File: rtl/xmem_lane_chk.sv
module xmem_lane_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_wide,
   input logic cfg_bsel,
   input logic rsp_done,
   input logic bus_cs_n,
   input logic bus_rd_n,
   input logic bus_wr_lo_n,
   input logic bus_wr_hi_n,
   input logic bus_a0_lb_n,
   input logic bus_dq_oe
);
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cs_n |-> (bus_rd_n && bus_wr_lo_n && bus_wr_hi_n && bus_a0_lb_n
                    && !bus_dq_oe && !rsp_done));

   // R2
   strobe_early_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd_n || !bus_wr_lo_n) |=> !bus_cs_n);

   // R2
   done_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> !bus_cs_n);

   // R2
   release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_cs_n) |-> $past(rsp_done));

   // R3
   bw_a0_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wide && !cfg_bsel) |-> bus_a0_lb_n);

   // R8
   narrow_hi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wide |-> bus_wr_hi_n);

   // R10
   read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> (!bus_dq_oe && bus_wr_lo_n));
endmodule

bind xmem_lane_ctrl xmem_lane_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_wide    (cfg_wide),
   .cfg_bsel    (cfg_bsel),
   .rsp_done    (rsp_done),
   .bus_cs_n    (bus_cs_n),
   .bus_rd_n    (bus_rd_n),
   .bus_wr_lo_n (bus_wr_lo_n),
   .bus_wr_hi_n (bus_wr_hi_n),
   .bus_a0_lb_n (bus_a0_lb_n),
   .bus_dq_oe   (bus_dq_oe)
);

// File: tb/sim_xmem_lane_ctrl.sv
module sim_xmem_lane_ctrl;
   localparam int AW = 20;
   localparam int DW = 16;
   localparam int NVEC = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_write = 1'b0;
   logic          req_half = 1'b0;
   logic [DW-1:0] req_wdata = '0;
   logic          cfg_wide = 1'b1;
   logic          cfg_bsel = 1'b0;
   logic [DW-1:0] rsp_rdata;
   logic          rsp_done;
   logic [AW-2:0] bus_addr;
   logic [DW-1:0] bus_dq_o;
   logic          bus_dq_oe;
   logic [DW-1:0] bus_dq_i;
   logic          bus_cs_n, bus_rd_n, bus_wr_lo_n, bus_wr_hi_n, bus_a0_lb_n;
   logic [7:0]    rd_even = 8'h00;
   logic [7:0]    rd_odd = 8'h00;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   // memory model: wide bus returns both bytes, narrow bus the addressed byte
   assign bus_dq_i = cfg_wide ? {rd_odd, rd_even}
                              : {8'h00, (bus_a0_lb_n ? rd_odd : rd_even)};

   xmem_lane_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_half(req_half), .req_wdata(req_wdata),
      .cfg_wide(cfg_wide), .cfg_bsel(cfg_bsel), .rsp_rdata(rsp_rdata),
      .rsp_done(rsp_done), .bus_addr(bus_addr), .bus_dq_o(bus_dq_o),
      .bus_dq_oe(bus_dq_oe), .bus_dq_i(bus_dq_i), .bus_cs_n(bus_cs_n),
      .bus_rd_n(bus_rd_n), .bus_wr_lo_n(bus_wr_lo_n), .bus_wr_hi_n(bus_wr_hi_n),
      .bus_a0_lb_n(bus_a0_lb_n)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] pins();
      return {bus_rd_n, bus_wr_lo_n, bus_wr_hi_n, bus_a0_lb_n};
   endfunction

   // {wide, bsel, write, half, addr0, strobe-cycle pins, end-cycle pins}
   // pins = {rd_n, wr_lo_n, wr_hi_n, a0_lb_n}
   localparam logic [12:0] VEC [NVEC] = '{
      13'b10100_1011_1111, 13'b10101_1101_1111, 13'b10110_1001_1111,
      13'b10001_0111_1111, 13'b10010_0111_1111, 13'b11100_1010_1110,
      13'b11101_1001_1101, 13'b11110_1000_1100, 13'b11000_0110_1110,
      13'b11011_0100_1100, 13'b01101_1011_1111, 13'b00100_1010_1110,
      13'b00001_0111_1111, 13'b00000_0110_1110
   };

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [12:0] v;
      string       rq;
      logic [15:0] ew, er;

      // R1 reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "pins idle", {27'd0, bus_cs_n, pins()}, 32'h1F);
      chk("R1", "oe/done idle", {bus_dq_oe, rsp_done}, 0);
      chk("R1", "addr/rdata reset", {bus_addr, rsp_rdata}, 0);

      for (int i = 0; i < NVEC; i++) begin
         v = VEC[i];
         cfg_wide  = v[12];
         cfg_bsel  = v[11];
         req_write = v[10];
         req_half  = v[9];
         req_addr  = {19'(i * 4919 + 165), v[8]};
         req_wdata = 16'h5A00 ^ 16'(i * 16'h1313);
         rd_even   = 8'h30 + 8'(i);
         rd_odd    = 8'hC0 + 8'(i);
         req_valid = 1'b1;
         if (!v[12]) rq = "R8 R6";
         else if (v[11]) rq = "R5 R6";
         else if (v[10]) rq = "R3 R6";
         else rq = "R4 R6";
         ew = (v[12] && v[9]) ? req_wdata : {req_wdata[7:0], req_wdata[7:0]};
         er = (v[12] && v[9]) ? {rd_odd, rd_even} : {8'h00, (v[8] ? rd_odd : rd_even)};
         @(negedge clk);
         req_valid = 1'b0;
         chk("R2", "cs strobe cycle", bus_cs_n, 0);
         chk(rq, "strobe pins", pins(), v[7:4]);
         chk("R7", "bus addr", bus_addr, req_addr[AW-1:1]);
         chk("R10", "oe strobe", bus_dq_oe, v[10]);
         if (v[10]) chk("R10", "write data", bus_dq_o, ew);
         @(negedge clk);
         chk("R2", "cs end cycle", bus_cs_n, 0);
         chk(rq, "end pins", pins(), v[3:0]);
         chk("R2", "done", rsp_done, 1);
         if (!v[10]) chk("R10", "read data", rsp_rdata, er);
         @(negedge clk);
         chk("R2", "release", {bus_cs_n, rsp_done}, 2'b10);
      end

      // R9 narrow halfword write at an odd address: low byte first
      cfg_wide = 1'b0; cfg_bsel = 1'b0;
      req_write = 1'b1; req_half = 1'b1; req_addr = 20'h00447; req_wdata = 16'hBEEF;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9", "beat0 strobe pins", pins(), 4'b1010);
      chk("R9", "beat0 data", bus_dq_o, 16'hEFEF);
      chk("R7", "narrow addr", bus_addr, 19'h00223);
      @(negedge clk);
      chk("R9", "beat0 end pins/cs", {bus_cs_n, pins()}, 5'b01110);
      chk("R9", "no done after beat0", rsp_done, 0);
      @(negedge clk);
      chk("R9", "beat1 strobe pins/cs", {bus_cs_n, pins()}, 5'b01011);
      chk("R9", "beat1 data", bus_dq_o, 16'hBEBE);
      @(negedge clk);
      chk("R9", "beat1 end done", {bus_cs_n, rsp_done}, 2'b01);
      @(negedge clk);
      chk("R9", "release", bus_cs_n, 1);

      // R9 narrow halfword read
      req_write = 1'b0; req_addr = 20'h00A10; rd_even = 8'h5A; rd_odd = 8'hE1;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9", "read beat0 pins", pins(), 4'b0110);
      @(negedge clk);
      @(negedge clk);
      chk("R9", "read beat1 pins", pins(), 4'b0111);
      @(negedge clk);
      chk("R9", "read done", rsp_done, 1);
      chk("R9", "read data", rsp_rdata, 16'hE15A);
      @(negedge clk);

      // R11 request held and changed while busy
      cfg_wide = 1'b1; cfg_bsel = 1'b1;
      req_write = 1'b1; req_half = 1'b0; req_addr = 20'h01000; req_wdata = 16'h0033;
      req_valid = 1'b1;
      @(negedge clk);
      req_addr = 20'h02001; req_write = 1'b0;
      chk("R11", "busy addr", bus_addr, 19'h00800);
      chk("R11", "busy strobe pins", pins(), 4'b1010);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R11", "busy end addr/pins", {bus_addr, pins()}, {19'h00800, 4'b1110});
      @(negedge clk);
      chk("R11", "no new access", bus_cs_n, 1);
      @(negedge clk);
      chk("R11", "still idle", bus_cs_n, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule